// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Transmit Controller

This block drives the transmit side of a single USB device IN endpoint. It has two packet buffers that are used in ping-pong fashion. Software loads bytes one per cycle through a load port. A buffer is handed to the host side once it holds a full packet. Software can also hand it over early by setting a short-packet flag in the control/status register, which covers short and zero-length packets.

A simplified host-side interface stands in for the bus. It presents IN tokens, pulls bytes one at a time and acknowledges delivered packets. For each token the block either starts a transfer from the oldest armed buffer or answers with a NAK. It keeps status bits for buffer service, packet completion, underrun and the short-packet flag. Buffers are flushed on a software request or on a configuration-change pulse from the bus. Completion and underrun drive a single interrupt request line.

Top module: `in_ep_tx`

## Requirements
- R1: After reset `csr_rdata` is 8'h01, and `irq`, `tok_go`, `tok_nak`, `rd_valid` and `ld_ovf` are all 0.
- R2: The service bit `csr_rdata[0]` is 1 while zero or one buffers are armed. It is 0 while both buffers are armed.
- R3: A buffer is armed when its MAX_PKT-th byte is loaded, or when software writes 1 to bit 7. While an armed short packet waits, bit 7 reads 1. It returns to 0 after that packet is acknowledged.
- R4: An IN token draws a one-cycle response on the next cycle. If a buffer is armed, `tok_go` is asserted and `tx_len` gives the length of the oldest armed buffer. If none is armed and bit 1 is set, `tok_nak` is asserted. If none is armed and bit 1 is clear, `tok_go` is asserted with `tx_len` of 0.
- R5: Each `rd_req` during a transfer returns the next byte of the packet on `rd_data`, with `rd_valid` high on the following cycle. Bytes come out in load order.
- R6: The completion bit (bit 1) is set when `pkt_ack` ends a transfer of an armed buffer. Writing 1 to bit 1 clears it.
- R7: `irq` equals (bit 1 AND `irq_en` AND NOT `irq_mask`) OR bit 3.
- R8: A `rd_req` during a transfer that has no bytes left sets the underrun bit (bit 3) and returns no `rd_valid`. Writing 1 to bit 3 clears the underrun bit.
- R9: Writing 1 to bit 2, or a pulse on `cfg_flush`, empties both buffers. Bit 2 always reads 0. Bits 1 and 3 keep their values across a flush.
- R10: Bits 6:4 read as 0, and writing them has no effect on the register.
- R11: A byte loaded while the target buffer is armed is dropped, and `ld_ovf` goes high and stays high.
- R12: A pending completion bit does not stop the next armed buffer from being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value {short, 000, underrun, 0, complete, service} |
| ld_valid | input | 1 | Byte load strobe |
| ld_data | input | DW | Byte to load |
| ld_ovf | output | 1 | Sticky dropped-load indication |
| cfg_flush | input | 1 | Configuration-change flush pulse |
| irq_en | input | 1 | Transmit interrupt enable |
| irq_mask | input | 1 | Completion interrupt mask for DMA operation |
| irq | output | 1 | Interrupt request |
| tok_in | input | 1 | IN token pulse |
| tok_go | output | 1 | Token accepted, transfer started |
| tok_nak | output | 1 | Token answered with NAK |
| tx_len | output | CW | Byte length of the started transfer |
| rd_req | input | 1 | Host byte request |
| rd_valid | output | 1 | Returned byte valid |
| rd_data | output | DW | Returned byte |
| pkt_ack | input | 1 | Host acknowledges end of transfer |

## Verification
Token responses, `tx_len` and returned bytes come from registers. They are due one cycle after the edge that samples the request, so the bench reads them at the falling edge that follows that edge. Register writes, loads and flushes change `csr_rdata` and `irq` from the first rising edge after the strobe, and the bench checks them at the next falling edge. A monitor at every falling edge pops the byte scoreboard whenever `rd_valid` is high, so returned bytes are compared in the same cycle they appear.

// File: rtl/in_ep_tx.sv
module in_ep_tx #(
  parameter int MAX_PKT = 256,
  parameter int DW = 8,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_wr,
  input  logic [7:0]    csr_wdata,
  output logic [7:0]    csr_rdata,
  input  logic          ld_valid,
  input  logic [DW-1:0] ld_data,
  output logic          ld_ovf,
  input  logic          cfg_flush,
  input  logic          irq_en,
  input  logic          irq_mask,
  output logic          irq,
  input  logic          tok_in,
  output logic          tok_go,
  output logic          tok_nak,
  output logic [CW-1:0] tx_len,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          pkt_ack
);

  logic [DW-1:0] mem [2][MAX_PKT];
  logic [CW-1:0] cnt [2];
  logic [1:0]    armed, shrt;
  logic          wsel, rsel, sending, act_valid;
  logic [CW-1:0] rptr;
  logic          tpc, tur;

  logic [CW-1:0] cnt_n;
  logic flush, tsp_w, ld_ok, arm_w, tok_ok, head_rdy, start, rd_ok, under, done;
  logic unused_bits;

  assign unused_bits = ^{csr_wdata[6:4], csr_wdata[0]};

  assign flush    = cfg_flush | (csr_wr & csr_wdata[2]);
  assign tsp_w    = csr_wr & csr_wdata[7];
  assign ld_ok    = ld_valid & ~armed[wsel] & ~flush;
  assign cnt_n    = cnt[wsel] + CW'(1);
  assign arm_w    = ~flush & ~armed[wsel] & (tsp_w | (ld_ok & (cnt_n == CW'(MAX_PKT))));
  assign head_rdy = armed[rsel];
  assign tok_ok   = tok_in & ~sending & ~flush;
  assign start    = tok_ok & (head_rdy | ~tpc);
  assign rd_ok    = rd_req & sending & act_valid & (rptr < cnt[rsel]);
  assign under    = rd_req & sending & ~rd_ok;
  assign done     = pkt_ack & sending & act_valid & ~flush;

  assign csr_rdata = {(shrt != 2'b00), 3'b000, tur, 1'b0, tpc, (armed != 2'b11)};
  assign irq       = (tpc & irq_en & ~irq_mask) | tur;

  always_ff @(posedge clk) begin
    if (ld_ok) mem[wsel][cnt[wsel][AW-1:0]] <= ld_data;
    if (rd_ok) rd_data <= mem[rsel][rptr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= '0; shrt <= '0; cnt[0] <= '0; cnt[1] <= '0;
      wsel <= 1'b0; rsel <= 1'b0; sending <= 1'b0; act_valid <= 1'b0;
      rptr <= '0; tpc <= 1'b0; tur <= 1'b0; ld_ovf <= 1'b0;
      tok_go <= 1'b0; tok_nak <= 1'b0; tx_len <= '0; rd_valid <= 1'b0;
    end else begin
      tok_go   <= start;
      tok_nak  <= tok_ok & ~head_rdy & tpc;
      rd_valid <= rd_ok;
      if (start) tx_len <= head_rdy ? cnt[rsel] : '0;

      if (done) tpc <= 1'b1;
      else if (csr_wr & csr_wdata[1]) tpc <= 1'b0;
      if (under) tur <= 1'b1;
      else if (csr_wr & csr_wdata[3]) tur <= 1'b0;
      if (ld_valid & armed[wsel] & ~flush) ld_ovf <= 1'b1;

      if (flush) begin
        armed <= '0; shrt <= '0; cnt[0] <= '0; cnt[1] <= '0;
        wsel <= 1'b0; rsel <= 1'b0; sending <= 1'b0; act_valid <= 1'b0;
        rptr <= '0;
      end else begin
        if (ld_ok) cnt[wsel] <= cnt_n;
        if (arm_w) begin
          armed[wsel] <= 1'b1;
          shrt[wsel]  <= tsp_w;
          wsel        <= ~wsel;
        end
        if (done) begin
          armed[rsel] <= 1'b0;
          shrt[rsel]  <= 1'b0;
          cnt[rsel]   <= '0;
          rsel        <= ~rsel;
          sending     <= 1'b0;
          act_valid   <= 1'b0;
        end else if (pkt_ack & sending) begin
          sending   <= 1'b0;
          act_valid <= 1'b0;
        end
        if (start) begin
          sending   <= 1'b1;
          act_valid <= head_rdy;
          rptr      <= '0;
        end else if (rd_ok) begin
          rptr <= rptr + CW'(1);
        end
      end
    end
  end

  p_resp_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_go && tok_nak));
  p_nak_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in && !sending && !flush && armed == 2'b00 && tpc |=> tok_nak);
  p_tpc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> tpc);
  p_under_r8: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> tur && !rd_valid);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (armed == 2'b00) && !sending);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ovf |=> ld_ovf);
  p_irq_tur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tur |-> irq);

endmodule

// File: tb/tb_in_ep_tx.sv
`timescale 1ns/1ps
module tb_in_ep_tx;
  localparam int P  = 16;
  localparam int DW = 8;
  localparam int CW = $clog2(P + 1);

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0, ld_valid = 0, cfg_flush = 0, irq_en = 1, irq_mask = 0;
  logic tok_in = 0, rd_req = 0, pkt_ack = 0;
  logic [7:0] csr_wdata = 0, csr_rdata;
  logic [DW-1:0] ld_data = 0, rd_data;
  logic ld_ovf, irq, tok_go, tok_nak, rd_valid;
  logic [CW-1:0] tx_len;

  int total = 0, bad = 0;
  logic [DW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  in_ep_tx #(.MAX_PKT(P), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ovf(ld_ovf), .cfg_flush(cfg_flush), .irq_en(irq_en),
    .irq_mask(irq_mask), .irq(irq), .tok_in(tok_in), .tok_go(tok_go),
    .tok_nak(tok_nak), .tx_len(tx_len), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .pkt_ack(pkt_ack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_csr(input string tag, input logic [7:0] exp);
    chk(csr_rdata == exp, tag, csr_rdata, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected byte", rd_data, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R5 byte order", rd_data, e);
      end
    end
  end

  task automatic load(input logic [DW-1:0] b, input bit kept);
    ld_valid = 1; ld_data = b;
    if (kept) exp_q.push_back(b);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic load_n(input int n, input int base);
    for (int i = 0; i < n; i++) load(DW'(base + i), 1);
  endtask

  task automatic csr_w(input logic [7:0] v);
    csr_wr = 1; csr_wdata = v;
    @(negedge clk);
    csr_wr = 0; csr_wdata = 0;
  endtask

  task automatic token(input bit go, input bit nak, input int len, input string tag);
    tok_in = 1;
    @(negedge clk);
    tok_in = 0;
    chk(tok_go == go, {tag, " go"}, tok_go, go);
    chk(tok_nak == nak, {tag, " nak"}, tok_nak, nak);
    if (go) chk(tx_len == CW'(len), {tag, " len"}, tx_len, len);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      rd_req = 1;
      @(negedge clk);
      rd_req = 0;
    end
  endtask

  task automatic ack;
    pkt_ack = 1;
    @(negedge clk);
    pkt_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_csr("R1 csr", 8'h01);
    chk(!irq && !tok_go && !tok_nak && !rd_valid && !ld_ovf, "R1 outputs", 1, 0);

    // R3 full packet arms buffer 0; R2 one armed keeps service bit
    load_n(P, 8'h10);
    chk_csr("R2 one armed", 8'h01);
    // R3 short packet armed by bit 7; R2 both armed clears service bit
    load_n(3, 8'h40);
    csr_w(8'h80);
    chk_csr("R2 R3 both armed", 8'h80);

    // R11 load into armed buffer dropped, sticky flag
    load(8'hEE, 0);
    chk(ld_ovf == 1, "R11 ovf", ld_ovf, 1);

    // R10 reserved bits ignored
    csr_w(8'h70);
    chk_csr("R10 reserved", 8'h80);

    // R4 token serves oldest; R5 bytes; R6 completion
    token(1, 0, P, "R4 full");
    read_n(P);
    ack;
    chk_csr("R6 tpc set", 8'h83);
    chk(irq == 1, "R7 irq on tpc", irq, 1);
    irq_mask = 1;
    @(negedge clk);
    chk(irq == 0, "R7 irq masked", irq, 0);

    // R12 pending completion does not block next armed buffer
    token(1, 0, 3, "R12 short");
    read_n(3);
    ack;
    chk_csr("R3 tsp cleared", 8'h03);
    chk(ld_ovf == 1, "R11 ovf sticky", ld_ovf, 1);

    // R4 NAK with completion pending and nothing armed
    token(0, 1, 0, "R4 nak");
    // R6 write-1-to-clear
    csr_w(8'h02);
    chk_csr("R6 tpc cleared", 8'h01);

    // R4 empty transfer; R8 underrun
    token(1, 0, 0, "R4 empty");
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    chk(rd_valid == 0, "R8 no data", rd_valid, 0);
    chk_csr("R8 tur set", 8'h09);
    chk(irq == 1, "R7 irq on tur", irq, 1);
    ack;
    csr_w(8'h08);
    chk_csr("R8 tur cleared", 8'h01);
    chk(irq == 0, "R7 irq idle", irq, 0);

    // R9 software flush
    load_n(P, 8'h60);
    load_n(2, 8'h90);
    chk_csr("R9 before flush", 8'h01);
    csr_w(8'h04);
    exp_q.delete();
    chk_csr("R9 flushed", 8'h01);
    load_n(2, 8'hA0);
    csr_w(8'h80);
    chk_csr("R9 fresh short", 8'h81);
    token(1, 0, 2, "R9 after flush");
    read_n(2);
    ack;
    chk_csr("R9 tpc", 8'h03);

    // R9 configuration flush keeps completion bit
    load_n(P, 8'hB0);
    cfg_flush = 1;
    @(negedge clk);
    cfg_flush = 0;
    exp_q.delete();
    chk_csr("R9 cfg flush", 8'h03);
    token(0, 1, 0, "R9 emptied");
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule